// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block holds a small, fully associative set of page translations. Each entry carries a virtual page number tag, a physical page number, an address-space number and a global flag. A lookup port presents a virtual address and the current address-space number. In the same cycle the block returns a hit flag, the physical page, and the full physical address. After the physical address is formed, a cacheability stage inspects it. An address with the uncached-select bit set is flagged as uncached. Its high bits are stripped, unless it falls in the internal register I/O window, in which case a fault is reported instead.

Maintenance commands arrive on a separate set of ports, and at most one is carried out per clock. Insert places a translation in the slot named by a round-robin victim pointer. Three invalidations are provided: clear everything, clear all entries that are not global, and clear the entries that one page and address-space pair would hit. A lookup in the same cycle as a command sees the contents from before that command. The command's effect shows from the next cycle on.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and the victim pointer is 0, so every lookup misses until an insert.
- R2: A lookup hits an entry only when the entry is valid, its tag equals the request page number, and either its global flag is set or its stored address-space number equals the request's.
- R3: When several entries hit, the lowest-indexed one supplies the physical page.
- R4: Insert writes the slot at the victim pointer and marks it valid, overwriting any entry there. It then advances the pointer, which wraps from DEPTH-1 to 0.
- R5: Flush-all invalidates every entry and returns the victim pointer to 0.
- R6: Flush-processes invalidates every non-global entry and keeps every global entry.
- R7: Flush-address invalidates exactly the entries that would hit for its page number and address-space number, global ones included.
- R8: Priority is flush-all, then flush-processes, then flush-address, then insert. Only the highest asserted command acts in a cycle, and the others are ignored.
- R9: A lookup reflects the contents from before the edge. A command's effect is visible from the cycle after it is presented.
- R10: The physical address is {ppn, page offset}, with a 13-bit offset. On a hit, lk_uncached equals physical address bit UC_BIT (default 43).
- R11: With UC_BIT = 43, an uncached hit outside the I/O window has physical address bits 42 to 35 cleared. Every other hit passes the address unchanged.
- R12: The I/O window is an uncached address whose bits UC_BIT-1 and UC_BIT-2 are both 1. Such a hit raises lk_fault and passes its address unstripped.
- R13: On a miss, lk_ppn, lk_paddr, lk_uncached and lk_fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | VA_W (43) | Lookup virtual address |
| lk_asn | input | ASN_W (8) | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W (31) | Physical page of the hitting entry |
| lk_paddr | output | PA_W (44) | Physical address after the cacheability stage |
| lk_uncached | output | 1 | Access is uncacheable |
| lk_fault | output | 1 | Access targets the I/O register window |
| cmd_flush_all | input | 1 | Invalidate all entries, reset victim pointer |
| cmd_flush_proc | input | 1 | Invalidate all non-global entries |
| cmd_flush_addr | input | 1 | Invalidate entries hit by cmd_vpn/cmd_asn |
| cmd_insert | input | 1 | Write a new entry at the victim pointer |
| cmd_vpn | input | VPN_W (30) | Page number for insert or flush-address |
| cmd_asn | input | ASN_W (8) | Address-space number for insert or flush-address |
| cmd_ppn | input | PPN_W (31) | Physical page for insert |
| cmd_global | input | 1 | Global flag for insert |

## Verification
A lookup and a maintenance command can occur in the same cycle. The lookup must then answer from the old contents: an insert or flush of the very page being looked up must not show until the following cycle. The bench provokes this directly, by inserting and flushing the page it is looking up in the same cycle, and again through random traffic that draws from a small pool of pages and address spaces. It also provokes it when several command inputs are raised together. Each cycle's outputs are judged against a bench model whose state is updated only after the clock edge.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [2:0] {
    TC_IDLE      = 3'd0,
    TC_CLR_ALL   = 3'd1,
    TC_CLR_PROC  = 3'd2,
    TC_CLR_PAGE  = 3'd3,
    TC_FILL      = 3'd4
  } tlb_cmd_e;

endpackage

// File: rtl/tlb_cmd_arb.sv
module tlb_cmd_arb
  import asid_tlb_pkg::*;
(
  input  logic     req_clr_all,
  input  logic     req_clr_proc,
  input  logic     req_clr_page,
  input  logic     req_fill,
  output tlb_cmd_e cmd_sel
);

  always_comb begin
    if (req_clr_all)       cmd_sel = TC_CLR_ALL;
    else if (req_clr_proc) cmd_sel = TC_CLR_PROC;
    else if (req_clr_page) cmd_sel = TC_CLR_PAGE;
    else if (req_fill)     cmd_sel = TC_FILL;
    else                   cmd_sel = TC_IDLE;
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int DEPTH = 16,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [DEPTH-1:0] valid_q,
  input  logic [DEPTH-1:0] glob_q,
  input  logic [VPN_W-1:0] tag_q [DEPTH],
  input  logic [ASN_W-1:0] asn_q [DEPTH],
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [ASN_W-1:0] req_asn,
  output logic [DEPTH-1:0] hit_vec
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic tag_eq;
    logic space_ok;
    assign tag_eq   = (tag_q[i] == req_vpn);
    assign space_ok = glob_q[i] | (asn_q[i] == req_asn);
    assign hit_vec[i] = valid_q[i] & tag_eq & space_ok;
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import asid_tlb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8,
  parameter int PPN_W = 31,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlb_cmd_e         cmd_sel,
  input  logic [DEPTH-1:0] page_hits,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [ASN_W-1:0] wr_asn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_glob,
  output logic [DEPTH-1:0] valid_q,
  output logic [DEPTH-1:0] glob_q,
  output logic [VPN_W-1:0] tag_q [DEPTH],
  output logic [ASN_W-1:0] asn_q [DEPTH],
  output logic [PPN_W-1:0] ppn_q [DEPTH],
  output logic [PTR_W-1:0] vptr_q
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] valid_d;
  logic             valid_en;
  logic [PTR_W-1:0] vptr_d;
  logic             vptr_en;
  logic [DEPTH-1:0] fill_slot;
  logic             fill_en;

  always_comb begin
    fill_slot = '0;
    fill_slot[vptr_q] = 1'b1;
  end

  assign fill_en = (cmd_sel == TC_FILL);

  // next state of the valid bits
  always_comb begin
    valid_d  = valid_q;
    valid_en = 1'b1;
    unique case (cmd_sel)
      TC_CLR_ALL:  valid_d = '0;
      TC_CLR_PROC: valid_d = valid_q & glob_q;
      TC_CLR_PAGE: valid_d = valid_q & ~page_hits;
      TC_FILL:     valid_d = valid_q | fill_slot;
      default:     valid_en = 1'b0;
    endcase
  end

  // next state of the victim pointer
  always_comb begin
    vptr_d  = vptr_q;
    vptr_en = 1'b0;
    if (cmd_sel == TC_CLR_ALL) begin
      vptr_d  = '0;
      vptr_en = 1'b1;
    end else if (fill_en) begin
      vptr_d  = (vptr_q == LAST_SLOT) ? '0 : vptr_q + PTR_W'(1);
      vptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      vptr_q  <= '0;
    end else begin
      if (valid_en) valid_q <= valid_d;
      if (vptr_en)  vptr_q  <= vptr_d;
    end
  end

  // payload storage, no reset: only qualified by valid_q
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = fill_en & fill_slot[i];
    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[i]  <= wr_vpn;
        asn_q[i]  <= wr_asn;
        ppn_q[i]  <= wr_ppn;
        glob_q[i] <= wr_glob;
      end
    end
  end

endmodule

// File: rtl/tlb_uc_filter.sv
module tlb_uc_filter #(
  parameter int PA_W   = 44,
  parameter int UC_BIT = 43
) (
  input  logic            hit,
  input  logic [PA_W-1:0] pa_raw,
  output logic [PA_W-1:0] pa_out,
  output logic            uncached,
  output logic            io_fault
);

  logic io_win;

  assign uncached = hit & pa_raw[UC_BIT];
  assign io_win   = pa_raw[UC_BIT-1] & pa_raw[UC_BIT-2];
  assign io_fault = uncached & io_win;

  if (UC_BIT == 43) begin : g_strip
    localparam int STRIP_HI = UC_BIT - 1;
    localparam int STRIP_LO = UC_BIT - 8;
    localparam logic [PA_W-1:0] STRIP_MASK =
      (PA_W'(1) << (STRIP_HI + 1)) - (PA_W'(1) << STRIP_LO);
    always_comb begin
      if (!hit)                       pa_out = '0;
      else if (uncached && !io_win)   pa_out = pa_raw & ~STRIP_MASK;
      else                            pa_out = pa_raw;
    end
  end else begin : g_pass
    assign pa_out = hit ? pa_raw : '0;
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VPN_W  = 30,
  parameter int ASN_W  = 8,
  parameter int PPN_W  = 31,
  parameter int OFS_W  = 13,
  parameter int UC_BIT = 43,
  localparam int VA_W  = VPN_W + OFS_W,
  localparam int PA_W  = PPN_W + OFS_W,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_uncached,
  output logic             lk_fault,
  input  logic             cmd_flush_all,
  input  logic             cmd_flush_proc,
  input  logic             cmd_flush_addr,
  input  logic             cmd_insert,
  input  logic [VPN_W-1:0] cmd_vpn,
  input  logic [ASN_W-1:0] cmd_asn,
  input  logic [PPN_W-1:0] cmd_ppn,
  input  logic             cmd_global
);

  tlb_cmd_e         cmd_sel;
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] glob_q;
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [ASN_W-1:0] asn_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [PTR_W-1:0] vptr_q;
  logic [DEPTH-1:0] lk_hits;
  logic [DEPTH-1:0] page_hits;
  logic [PTR_W-1:0] hit_idx;
  logic [PPN_W-1:0] sel_ppn;
  logic [PA_W-1:0]  pa_raw;

  tlb_cmd_arb u_arb (
    .req_clr_all  (cmd_flush_all),
    .req_clr_proc (cmd_flush_proc),
    .req_clr_page (cmd_flush_addr),
    .req_fill     (cmd_insert),
    .cmd_sel      (cmd_sel)
  );

  tlb_store #(
    .DEPTH (DEPTH), .VPN_W (VPN_W), .ASN_W (ASN_W), .PPN_W (PPN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_sel   (cmd_sel),
    .page_hits (page_hits),
    .wr_vpn    (cmd_vpn),
    .wr_asn    (cmd_asn),
    .wr_ppn    (cmd_ppn),
    .wr_glob   (cmd_global),
    .valid_q   (valid_q),
    .glob_q    (glob_q),
    .tag_q     (tag_q),
    .asn_q     (asn_q),
    .ppn_q     (ppn_q),
    .vptr_q    (vptr_q)
  );

  // lookup comparator bank
  tlb_match #(.DEPTH (DEPTH), .VPN_W (VPN_W), .ASN_W (ASN_W)) u_lk_match (
    .valid_q (valid_q),
    .glob_q  (glob_q),
    .tag_q   (tag_q),
    .asn_q   (asn_q),
    .req_vpn (lk_vaddr[VA_W-1:OFS_W]),
    .req_asn (lk_asn),
    .hit_vec (lk_hits)
  );

  // single-page invalidation comparator bank
  tlb_match #(.DEPTH (DEPTH), .VPN_W (VPN_W), .ASN_W (ASN_W)) u_pg_match (
    .valid_q (valid_q),
    .glob_q  (glob_q),
    .tag_q   (tag_q),
    .asn_q   (asn_q),
    .req_vpn (cmd_vpn),
    .req_asn (cmd_asn),
    .hit_vec (page_hits)
  );

  // lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lk_hits[i]) hit_idx = PTR_W'(i);
    end
  end

  assign lk_hit  = |lk_hits;
  assign sel_ppn = ppn_q[hit_idx];
  assign lk_ppn  = lk_hit ? sel_ppn : '0;
  assign pa_raw  = {sel_ppn, lk_vaddr[OFS_W-1:0]};

  tlb_uc_filter #(.PA_W (PA_W), .UC_BIT (UC_BIT)) u_uc (
    .hit      (lk_hit),
    .pa_raw   (pa_raw),
    .pa_out   (lk_paddr),
    .uncached (lk_uncached),
    .io_fault (lk_fault)
  );

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk
  import asid_tlb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input tlb_cmd_e         cmd_sel,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] glob_q,
  input logic [PTR_W-1:0] vptr_q,
  input logic             lk_hit,
  input logic             lk_uncached,
  input logic             lk_fault
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  // R5
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sel == TC_CLR_ALL |=> (valid_q == '0) && (vptr_q == '0));

  // R6
  clr_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sel == TC_CLR_PROC |=> (valid_q & ~glob_q) == '0);

  // R4
  fill_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sel == TC_FILL |=> valid_q[$past(vptr_q)] &&
      (vptr_q == (($past(vptr_q) == LAST_SLOT) ? '0 : $past(vptr_q) + PTR_W'(1))));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sel != TC_FILL) && (cmd_sel != TC_CLR_ALL) |=> $stable(vptr_q));

  // R13
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !lk_uncached && !lk_fault);

  // R12
  fault_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_uncached);

endmodule

bind asid_tlb asid_tlb_chk #(.DEPTH (DEPTH), .PTR_W (PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_sel     (cmd_sel),
  .valid_q     (valid_q),
  .glob_q      (glob_q),
  .vptr_q      (vptr_q),
  .lk_hit      (lk_hit),
  .lk_uncached (lk_uncached),
  .lk_fault    (lk_fault)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;

  localparam int DEPTH = 16;
  localparam int VPN_W = 30;
  localparam int ASN_W = 8;
  localparam int PPN_W = 31;
  localparam int OFS_W = 13;
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int RW    = 3 + PPN_W + PA_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [VA_W-1:0]  lk_vaddr;
  logic [ASN_W-1:0] lk_asn;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic [PA_W-1:0]  lk_paddr;
  logic             lk_uncached;
  logic             lk_fault;
  logic             cmd_flush_all, cmd_flush_proc, cmd_flush_addr, cmd_insert;
  logic [VPN_W-1:0] cmd_vpn;
  logic [ASN_W-1:0] cmd_asn;
  logic [PPN_W-1:0] cmd_ppn;
  logic             cmd_global;

  always #4 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk (clk), .rst_n (rst_n),
    .lk_vaddr (lk_vaddr), .lk_asn (lk_asn),
    .lk_hit (lk_hit), .lk_ppn (lk_ppn), .lk_paddr (lk_paddr),
    .lk_uncached (lk_uncached), .lk_fault (lk_fault),
    .cmd_flush_all (cmd_flush_all), .cmd_flush_proc (cmd_flush_proc),
    .cmd_flush_addr (cmd_flush_addr), .cmd_insert (cmd_insert),
    .cmd_vpn (cmd_vpn), .cmd_asn (cmd_asn), .cmd_ppn (cmd_ppn),
    .cmd_global (cmd_global)
  );

  // reference model
  bit               m_v   [DEPTH];
  bit               m_g   [DEPTH];
  logic [VPN_W-1:0] m_vpn [DEPTH];
  logic [ASN_W-1:0] m_asn [DEPTH];
  logic [PPN_W-1:0] m_ppn [DEPTH];
  int               m_ptr;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done  = 1'b0;

  function automatic logic [RW-1:0] expect_lk(input logic [VPN_W-1:0] vpn,
                                              input logic [ASN_W-1:0] asn,
                                              input logic [OFS_W-1:0] ofs);
    logic [PA_W-1:0] pa;
    logic            unc, io;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn)) begin
        pa  = {m_ppn[i], ofs};
        unc = pa[43];
        io  = unc && pa[42] && pa[41];
        if (unc && !io) pa[42:35] = 8'h00;
        return {1'b1, unc, io, m_ppn[i], pa};
      end
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_update(input bit fa, input bit fp, input bit fd, input bit ins,
                              input logic [VPN_W-1:0] cv, input logic [ASN_W-1:0] ca,
                              input logic [PPN_W-1:0] cp, input bit cg);
    if (fa) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
      m_ptr = 0;
    end else if (fp) begin
      for (int i = 0; i < DEPTH; i++) if (!m_g[i]) m_v[i] = 1'b0;
    end else if (fd) begin
      for (int i = 0; i < DEPTH; i++)
        if (m_vpn[i] == cv && (m_g[i] || m_asn[i] == ca)) m_v[i] = 1'b0;
    end else if (ins) begin
      m_v[m_ptr] = 1'b1; m_g[m_ptr] = cg; m_vpn[m_ptr] = cv;
      m_asn[m_ptr] = ca; m_ppn[m_ptr] = cp;
      m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
    end
  endtask

  task automatic step(input string tag, input bit fa, input bit fp, input bit fd, input bit ins,
                      input logic [VPN_W-1:0] cv, input logic [ASN_W-1:0] ca,
                      input logic [PPN_W-1:0] cp, input bit cg,
                      input logic [VPN_W-1:0] lv, input logic [ASN_W-1:0] la,
                      input logic [OFS_W-1:0] lo);
    @(negedge clk);
    cmd_flush_all = fa; cmd_flush_proc = fp; cmd_flush_addr = fd; cmd_insert = ins;
    cmd_vpn = cv; cmd_asn = ca; cmd_ppn = cp; cmd_global = cg;
    lk_vaddr = {lv, lo}; lk_asn = la;
    #1;
    check(tag, {lk_hit, lk_uncached, lk_fault, lk_ppn, lk_paddr}, expect_lk(lv, la, lo));
    @(posedge clk);
    model_update(fa, fp, fd, ins, cv, ca, cp, cg);
  endtask

  task automatic look(input string tag, input logic [VPN_W-1:0] lv,
                      input logic [ASN_W-1:0] la, input logic [OFS_W-1:0] lo);
    step(tag, 0, 0, 0, 0, '0, '0, '0, 0, lv, la, lo);
  endtask

  task automatic fill(input string tag, input logic [VPN_W-1:0] cv, input logic [ASN_W-1:0] ca,
                      input logic [PPN_W-1:0] cp, input bit cg);
    step(tag, 0, 0, 0, 1, cv, ca, cp, cg, cv, ca, 13'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    cmd_flush_all = 0; cmd_flush_proc = 0; cmd_flush_addr = 0; cmd_insert = 0;
    cmd_vpn = '0; cmd_asn = '0; cmd_ppn = '0; cmd_global = 0;
    lk_vaddr = '0; lk_asn = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look("R1 reset miss", 30'd0, 8'd0, 13'h0);
    look("R1 reset miss", 30'd5, 8'd3, 13'h1f);

    // R2: ASN rule and global flag; R9: same-cycle insert not yet visible
    step("R9 lookup during insert", 0, 0, 0, 1, 30'd5, 8'd3, 31'h0000_1234, 0, 30'd5, 8'd3, 13'h10);
    look("R2 asn match hit", 30'd5, 8'd3, 13'h10);
    look("R2 asn mismatch miss", 30'd5, 8'd4, 13'h10);
    fill("R2 global insert", 30'd6, 8'd1, 31'h0000_5678, 1);
    look("R2 global any asn", 30'd6, 8'd9, 13'h7);

    // R3: duplicate tag, lowest index wins
    fill("R3 dup a", 30'd7, 8'd1, 31'h0000_0aaa, 0);
    fill("R3 dup b", 30'd7, 8'd1, 31'h0000_0bbb, 0);
    look("R3 lowest index", 30'd7, 8'd1, 13'h3);

    // R7: flush-address hits both dups and also a global page; R9 same cycle
    step("R9 lookup during flush", 0, 0, 1, 0, 30'd7, 8'd1, '0, 0, 30'd7, 8'd1, 13'h3);
    look("R7 page flushed", 30'd7, 8'd1, 13'h3);
    step("R7 global flush", 0, 0, 1, 0, 30'd6, 8'd2, '0, 0, 30'd5, 8'd3, 13'h0);
    look("R7 global gone", 30'd6, 8'd2, 13'h0);
    look("R7 other page kept", 30'd5, 8'd3, 13'h0);

    // R6: process flush keeps globals
    fill("R6 global", 30'd9, 8'd2, 31'h0000_0999, 1);
    step("R6 flush proc", 0, 1, 0, 0, '0, '0, '0, 0, 30'd9, 8'd0, 13'h0);
    look("R6 global kept", 30'd9, 8'd0, 13'h0);
    look("R6 private gone", 30'd5, 8'd3, 13'h0);

    // R8: lower-priority commands ignored
    step("R8 flush-all beats insert", 1, 0, 0, 1, 30'd11, 8'd0, 31'h111, 0, 30'd9, 8'd0, 13'h0);
    look("R8 insert dropped", 30'd11, 8'd0, 13'h0);
    look("R5 all cleared", 30'd9, 8'd0, 13'h0);
    fill("R8 setup", 30'd12, 8'd0, 31'h222, 0);
    step("R8 flush-proc beats insert", 0, 1, 0, 1, 30'd13, 8'd0, 31'h333, 1, 30'd12, 8'd0, 13'h0);
    look("R8 insert dropped", 30'd13, 8'd0, 13'h0);
    step("R8 flush-addr beats insert", 0, 0, 1, 1, 30'd14, 8'd0, 31'h444, 1, 30'd14, 8'd0, 13'h0);
    look("R8 insert dropped", 30'd14, 8'd0, 13'h0);

    // R5 then R4: pointer reset and wrap
    step("R5 flush all", 1, 0, 0, 0, '0, '0, '0, 0, 30'd0, 8'd0, 13'h0);
    for (int i = 0; i <= DEPTH; i++) fill("R4 fill", 30'(100 + i), 8'd0, 31'(16'h100 + i), 0);
    look("R4 slot0 overwritten", 30'd100, 8'd0, 13'h0);
    look("R4 wrapped entry", 30'(100 + DEPTH), 8'd0, 13'h0);
    look("R4 slot1 kept", 30'd101, 8'd0, 13'h0);

    // R10..R12: cacheability stage
    fill("R10 uc", 30'd200, 8'd0, {3'b100, 28'h0fa_5c3b}, 0);
    look("R11 uc stripped", 30'd200, 8'd0, 13'h1abc);
    fill("R12 io", 30'd201, 8'd0, {3'b111, 28'h123_4567}, 0);
    look("R12 io fault", 30'd201, 8'd0, 13'h0155);
    fill("R10 cached", 30'd202, 8'd0, {3'b011, 28'hfff_ffff}, 0);
    look("R10 cached pass", 30'd202, 8'd0, 13'h1fff);
    look("R13 miss zero", 30'd203, 8'd0, 13'h1fff);

    // constrained random traffic over a small page/ASN pool
    for (int n = 0; n < 4000; n++) begin
      bit fa, fp, fd, ins, cg;
      logic [VPN_W-1:0] cv, lv;
      logic [ASN_W-1:0] ca, la;
      fa  = ($urandom % 64) == 0;
      fp  = ($urandom % 24) == 0;
      fd  = ($urandom % 8)  == 0;
      ins = ($urandom % 2)  == 0;
      cg  = ($urandom % 3)  == 0;
      cv  = 30'($urandom % 8);
      ca  = 8'($urandom % 4);
      lv  = ($urandom % 4 == 0) ? cv : 30'($urandom % 8);
      la  = 8'($urandom % 4);
      step("R2 R8 R9 random", fa, fp, fd, ins, cv, ca, 31'($urandom), cg, lv, la, 13'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule